// File: doc/BRIEF.md
# Cache Flush Sequencer with Bus Ownership

This block empties a look-aside cache by walking its tag store from the first index to the last. Software or a system controller raises an asynchronous flush request. Once that request has been seen high for the full synchronizer window, the block asks for the system bus. It touches the tag store for the sweep only after the bus is granted. Each entry is read: an invalid entry is skipped, a valid clean entry is cleared at once, and a valid dirty entry is first handed to the memory side through a write-back request/acknowledge pair and then cleared.

While the sequence is active, other masters may still put transactions on the bus, and the block snoops them. Any transaction other than a processor burst write is answered with a retry. A burst write replaces a whole line, so the block looks up that line in the tag store and clears it on a tag match, without retrying it. Snoop lookups take priority over the sweep on the single tag port. After the last index the bus request is dropped and a one-cycle done pulse is given. Only a synchronous reset can abort the sequence.

Top module: `l2_flush_seq`

## Requirements
- R1: A flush starts only when `flush_req_a` has been sampled high on SYNC_LEN (default 8) consecutive clock edges; `bus_req` then rises no more than 3 cycles later. A shorter high pulse has no effect.
- R2: After a start, `bus_req` is held high, and the sweep issues no tag store access while `bus_gnt` is low.
- R3: The sweep reads every index exactly once, in ascending order from 0 to 2^IDX_W-1. A read (`tag_en`=1, `tag_we`=0) returns `tag_rd_valid`/`tag_rd_dirty`/`tag_rd_tag` one cycle later.
- R4: A valid clean entry is cleared with a write (`tag_en`=1, `tag_we`=1 clears valid and dirty at `tag_idx`) and gets no write-back.
- R5: For a valid dirty entry, `wb_req` is raised with `wb_idx` and `wb_tag` of that entry and held stable until `wb_ack`. The entry is cleared only after the acknowledge.
- R6: An invalid entry is neither written nor written back.
- R7: While a flush is active, a snooped transaction whose `snoop_kind` is not burst write (kind codes: 0 read, 1 single write, 2 burst write, 3 other) makes `retry` high for exactly the next cycle. Otherwise `retry` is low.
- R8: While a flush is active, a burst write (kind 2) causes no retry. Its `snoop_line` holds {tag, index}, and the entry at that index is cleared if it is valid with a matching tag. Entries that do not match are untouched. Burst writes must be at least 3 cycles apart.
- R9: In the cycle after the last index is finished, `done` is high for one cycle and `bus_req` is low.
- R10: A flush request that arrives during a running flush is ignored. A request still held when the flush ends does not start a new one.
- R11: With `rst` high, `bus_req`, `wb_req`, `retry`, `done` and `tag_en` are low from the next cycle on, and an active flush is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| flush_req_a | input | 1 | Asynchronous flush request |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| tag_en | output | 1 | Tag store access enable |
| tag_we | output | 1 | Tag store write (clears entry) |
| tag_idx | output | IDX_W | Tag store index |
| tag_rd_valid | input | 1 | Read entry valid bit, one cycle after read |
| tag_rd_dirty | input | 1 | Read entry dirty bit |
| tag_rd_tag | input | TAG_W | Read entry tag |
| wb_req | output | 1 | Write-back request |
| wb_idx | output | IDX_W | Index of line to write back |
| wb_tag | output | TAG_W | Tag of line to write back |
| wb_ack | input | 1 | Write-back acknowledge |
| snoop_valid | input | 1 | A bus transaction is visible this cycle |
| snoop_kind | input | 2 | Transaction kind code |
| snoop_line | input | TAG_W+IDX_W | Line address {tag, index} of the transaction |
| retry | output | 1 | Retry response for the snooped transaction |
| done | output | 1 | One-cycle flush complete pulse |

## Verification
The bench fills the tag store with random mixes of invalid, clean and dirty entries, and acknowledges write-backs after random delays. This catches a design that clears a dirty line before its acknowledge, that writes back a clean line, or that skips or repeats an index. Request pulses one cycle shorter than the window check that a design with a short synchronizer does not start early. A grant that is held back checks that the design does not sweep before it owns the bus. Burst writes sent while the grant is withheld, with matching and non-matching tags, expose a design that retries burst writes or clears the wrong entry. Further cases are a request repeated during a run and held past its end (a design that restarts on a level would flush twice) and a reset in mid-sweep (a design that keeps requesting the bus would fail).

// File: rtl/l2f_pkg.sv
package l2f_pkg;

    typedef enum logic [2:0] {
        SW_IDLE,
        SW_REQ,
        SW_RD,
        SW_CHK,
        SW_WB,
        SW_INV,
        SW_DONE
    } sweep_state_e;

    typedef enum logic [1:0] {
        SN_IDLE,
        SN_RD,
        SN_CMP
    } snoop_phase_e;

    localparam logic [1:0] KIND_READ     = 2'd0;
    localparam logic [1:0] KIND_WR_SINGLE = 2'd1;
    localparam logic [1:0] KIND_BURST_WR = 2'd2;
    localparam logic [1:0] KIND_OTHER    = 2'd3;

    function automatic logic kind_needs_retry(input logic [1:0] kind);
        return kind != KIND_BURST_WR;
    endfunction

endpackage

// File: rtl/l2f_req_sync.sv
module l2f_req_sync #(
    parameter int SYNC_LEN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic req_async,
    output logic start_pulse
);
    logic [SYNC_LEN-1:0] shift_q;
    logic                full_q;
    logic                full;

    assign full = &shift_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            full_q  <= 1'b0;
        end else begin
            shift_q <= {shift_q[SYNC_LEN-2:0], req_async};
            full_q  <= full;
        end
    end

    // only the first cycle of a full window counts as a new request
    assign start_pulse = full & ~full_q;
endmodule

// File: rtl/l2f_sweep.sv
module l2f_sweep
    import l2f_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             bus_gnt,
    input  logic             ram_free,
    input  logic             rd_valid,
    input  logic             rd_dirty,
    input  logic [TAG_W-1:0] rd_tag,
    input  logic             wb_ack,
    output logic             bus_req,
    output logic             busy,
    output logic             done,
    output logic             ram_en,
    output logic             ram_we,
    output logic [IDX_W-1:0] ram_idx,
    output logic             wb_req,
    output logic [IDX_W-1:0] wb_idx,
    output logic [TAG_W-1:0] wb_tag
);
    localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

    sweep_state_e     st_q, st_d;
    logic [IDX_W-1:0] cnt_q;
    logic [TAG_W-1:0] tag_q;
    logic             last;
    logic             step;

    assign last = (cnt_q == LAST_IDX);

    always_comb begin
        st_d   = st_q;
        ram_en = 1'b0;
        ram_we = 1'b0;
        wb_req = 1'b0;
        done   = 1'b0;
        step   = 1'b0;
        unique case (st_q)
            SW_IDLE: if (start) st_d = SW_REQ;
            SW_REQ:  if (bus_gnt) st_d = SW_RD;
            SW_RD: begin
                ram_en = ram_free;
                if (ram_free) st_d = SW_CHK;
            end
            SW_CHK: begin
                if (rd_valid && rd_dirty) begin
                    st_d = SW_WB;
                end else if (rd_valid) begin
                    st_d = SW_INV;
                end else begin
                    st_d = last ? SW_DONE : SW_RD;
                    step = ~last;
                end
            end
            SW_WB: begin
                wb_req = 1'b1;
                if (wb_ack) st_d = SW_INV;
            end
            SW_INV: begin
                ram_en = ram_free;
                ram_we = ram_free;
                if (ram_free) begin
                    st_d = last ? SW_DONE : SW_RD;
                    step = ~last;
                end
            end
            SW_DONE: begin
                done = 1'b1;
                st_d = SW_IDLE;
            end
            default: st_d = SW_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SW_IDLE;
            cnt_q <= '0;
            tag_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == SW_IDLE)
                cnt_q <= '0;
            else if (step)
                cnt_q <= cnt_q + 1'b1;
            if (st_q == SW_CHK)
                tag_q <= rd_tag;
        end
    end

    assign bus_req = (st_q == SW_REQ) || (st_q == SW_RD) || (st_q == SW_CHK) ||
                     (st_q == SW_WB)  || (st_q == SW_INV);
    assign busy    = (st_q != SW_IDLE);
    assign ram_idx = cnt_q;
    assign wb_idx  = cnt_q;
    assign wb_tag  = tag_q;
endmodule

// File: rtl/l2f_snoop.sv
module l2f_snoop
    import l2f_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int TAG_W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   active,
    input  logic                   snoop_valid,
    input  logic [1:0]             snoop_kind,
    input  logic [TAG_W+IDX_W-1:0] snoop_line,
    input  logic                   rd_valid,
    input  logic [TAG_W-1:0]       rd_tag,
    output logic                   ram_en,
    output logic                   ram_we,
    output logic [IDX_W-1:0]       ram_idx,
    output logic                   busy,
    output logic                   retry
);
    snoop_phase_e     ph_q;
    logic [IDX_W-1:0] idx_q;
    logic [TAG_W-1:0] tag_q;
    logic             take;
    logic             hit;

    assign take = active && snoop_valid && !kind_needs_retry(snoop_kind) && (ph_q == SN_IDLE);
    assign hit  = (ph_q == SN_CMP) && rd_valid && (rd_tag == tag_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= SN_IDLE;
            idx_q <= '0;
            tag_q <= '0;
            retry <= 1'b0;
        end else begin
            retry <= active && snoop_valid && kind_needs_retry(snoop_kind);
            unique case (ph_q)
                SN_IDLE: if (take) begin
                    ph_q  <= SN_RD;
                    idx_q <= snoop_line[IDX_W-1:0];
                    tag_q <= snoop_line[TAG_W+IDX_W-1:IDX_W];
                end
                SN_RD:   ph_q <= SN_CMP;
                default: ph_q <= SN_IDLE;
            endcase
        end
    end

    assign ram_en  = (ph_q == SN_RD) || hit;
    assign ram_we  = hit;
    assign ram_idx = idx_q;
    assign busy    = (ph_q != SN_IDLE);
endmodule

// File: rtl/l2_flush_seq.sv
module l2_flush_seq
    import l2f_pkg::*;
#(
    parameter int IDX_W    = 4,
    parameter int TAG_W    = 8,
    parameter int SYNC_LEN = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   flush_req_a,
    output logic                   bus_req,
    input  logic                   bus_gnt,
    output logic                   tag_en,
    output logic                   tag_we,
    output logic [IDX_W-1:0]       tag_idx,
    input  logic                   tag_rd_valid,
    input  logic                   tag_rd_dirty,
    input  logic [TAG_W-1:0]       tag_rd_tag,
    output logic                   wb_req,
    output logic [IDX_W-1:0]       wb_idx,
    output logic [TAG_W-1:0]       wb_tag,
    input  logic                   wb_ack,
    input  logic                   snoop_valid,
    input  logic [1:0]             snoop_kind,
    input  logic [TAG_W+IDX_W-1:0] snoop_line,
    output logic                   retry,
    output logic                   done
);
    logic             start;
    logic             sw_busy;
    logic             sw_en, sw_we;
    logic [IDX_W-1:0] sw_idx;
    logic             sn_en, sn_we, sn_busy;
    logic [IDX_W-1:0] sn_idx;

    l2f_req_sync #(.SYNC_LEN(SYNC_LEN)) i_sync (
        .clk         (clk),
        .rst         (rst),
        .req_async   (flush_req_a),
        .start_pulse (start)
    );

    l2f_sweep #(.IDX_W(IDX_W), .TAG_W(TAG_W)) i_sweep (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .bus_gnt  (bus_gnt),
        .ram_free (~sn_busy),
        .rd_valid (tag_rd_valid),
        .rd_dirty (tag_rd_dirty),
        .rd_tag   (tag_rd_tag),
        .wb_ack   (wb_ack),
        .bus_req  (bus_req),
        .busy     (sw_busy),
        .done     (done),
        .ram_en   (sw_en),
        .ram_we   (sw_we),
        .ram_idx  (sw_idx),
        .wb_req   (wb_req),
        .wb_idx   (wb_idx),
        .wb_tag   (wb_tag)
    );

    l2f_snoop #(.IDX_W(IDX_W), .TAG_W(TAG_W)) i_snoop (
        .clk         (clk),
        .rst         (rst),
        .active      (sw_busy),
        .snoop_valid (snoop_valid),
        .snoop_kind  (snoop_kind),
        .snoop_line  (snoop_line),
        .rd_valid    (tag_rd_valid),
        .rd_tag      (tag_rd_tag),
        .ram_en      (sn_en),
        .ram_we      (sn_we),
        .ram_idx     (sn_idx),
        .busy        (sn_busy),
        .retry       (retry)
    );

    // snoop lookups own the single tag port whenever they are in flight
    always_comb begin
        if (sn_busy) begin
            tag_en  = sn_en;
            tag_we  = sn_we;
            tag_idx = sn_idx;
        end else begin
            tag_en  = sw_en;
            tag_we  = sw_we;
            tag_idx = sw_idx;
        end
    end
endmodule

// File: rtl/l2_flush_chk.sv
module l2_flush_chk #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_req,
    input logic             done,
    input logic             retry,
    input logic             wb_req,
    input logic             wb_ack,
    input logic [IDX_W-1:0] wb_idx,
    input logic [TAG_W-1:0] wb_tag,
    input logic             snoop_valid,
    input logic [1:0]       snoop_kind
);
    p_wb_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (wb_req && !wb_ack) |=> (wb_req && $stable(wb_idx) && $stable(wb_tag)));

    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_release_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> !bus_req);

    p_retry_other_r7: assert property (@(posedge clk) disable iff (rst)
        (snoop_valid && snoop_kind != 2'd2 && bus_req) |=> retry);

    p_no_retry_burst_r8: assert property (@(posedge clk) disable iff (rst)
        (snoop_valid && snoop_kind == 2'd2) |=> !retry);

    p_reset_quiet_r11: assert property (@(posedge clk)
        rst |=> (!bus_req && !wb_req && !retry && !done));
endmodule

bind l2_flush_seq l2_flush_chk #(.IDX_W(IDX_W), .TAG_W(TAG_W)) i_chk (.*);

// File: tb/test_l2_flush_seq.sv
module test_l2_flush_seq;
    localparam int IW = 4;
    localparam int TW = 8;
    localparam int N  = 1 << IW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          flush_req_a = 1'b0;
    logic          bus_req, bus_gnt = 1'b0;
    logic          tag_en, tag_we;
    logic [IW-1:0] tag_idx;
    logic          tag_rd_valid = 1'b0, tag_rd_dirty = 1'b0;
    logic [TW-1:0] tag_rd_tag = '0;
    logic          wb_req, wb_ack = 1'b0;
    logic [IW-1:0] wb_idx;
    logic [TW-1:0] wb_tag;
    logic          snoop_valid = 1'b0;
    logic [1:0]    snoop_kind = 2'd0;
    logic [TW+IW-1:0] snoop_line = '0;
    logic          retry, done;

    always #2.5 clk = ~clk;

    l2_flush_seq i_l2_flush_seq (.*);

    // tag store model
    logic          m_v [N];
    logic          m_d [N];
    logic [TW-1:0] m_t [N];

    always @(posedge clk) begin
        if (tag_en) begin
            if (tag_we) begin
                m_v[tag_idx] <= 1'b0;
                m_d[tag_idx] <= 1'b0;
            end else begin
                tag_rd_valid <= m_v[tag_idx];
                tag_rd_dirty <= m_d[tag_idx];
                tag_rd_tag   <= m_t[tag_idx];
            end
        end
    end

    int checks = 0, fails = 0, cyc = 0;
    bit gnt_hold = 1'b0;
    int gnt_wait = 0, ack_wait = 0;
    int snoop_win = 0;
    int exp_idx = 0, sweep_reads = 0, wb_cnt = 0, done_cnt = 0, rise_cnt = 0;
    bit wb_done [N];
    bit exp_retry = 1'b0, prev_req = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            summary();
        end
    end

    // grant and write-back acknowledge responders
    always @(negedge clk) begin
        if (!bus_req || gnt_hold) begin
            bus_gnt  <= 1'b0;
            gnt_wait = $urandom % 5;
        end else if (!bus_gnt) begin
            if (gnt_wait == 0) bus_gnt <= 1'b1;
            else gnt_wait--;
        end
        if (wb_ack) begin
            wb_ack   <= 1'b0;
            ack_wait = $urandom % 4;
        end else if (wb_req) begin
            if (ack_wait == 0) wb_ack <= 1'b1;
            else ack_wait--;
        end
    end

    // monitor: outputs show current state, inputs are those for the coming edge
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            if (exp_retry || retry)
                chk(retry == exp_retry, "R7 retry", retry, exp_retry);
            exp_retry = snoop_valid && snoop_kind != 2'd2 && (bus_req || done);
            if (bus_req && !prev_req) rise_cnt++;
            prev_req = bus_req;
            if (snoop_win == 0 && tag_en) begin
                chk(bus_gnt, "R2 access without grant", 0, 1);
                if (!tag_we) begin
                    chk(tag_idx == exp_idx[IW-1:0], "R3 sweep order", tag_idx, exp_idx);
                    exp_idx++;
                    sweep_reads++;
                end else begin
                    chk(m_v[tag_idx], "R6 write to invalid entry", 0, 1);
                    if (m_d[tag_idx])
                        chk(wb_done[tag_idx], "R5 clear before ack", 0, 1);
                    else
                        chk(!wb_done[tag_idx], "R4 clean line written back", 1, 0);
                end
            end
            if (wb_req) begin
                if (!(m_v[wb_idx] && m_d[wb_idx] && m_t[wb_idx] == wb_tag)) begin
                    chk(1'b0, "R5/R6 write-back line", wb_tag, m_t[wb_idx]);
                end
                if (wb_ack && !wb_done[wb_idx]) begin
                    wb_done[wb_idx] = 1'b1;
                    wb_cnt++;
                end
            end
            if (done) begin
                done_cnt++;
                chk(!bus_req, "R9 bus_req at done", bus_req, 0);
                chk(sweep_reads == N, "R9 done after last index", sweep_reads, N);
            end
            if (snoop_win > 0) snoop_win--;
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fill_store(output int dirty_n);
        dirty_n = 0;
        for (int i = 0; i < N; i++) begin
            m_v[i] = ($urandom % 3) != 0;
            m_d[i] = m_v[i] && ($urandom % 2);
            m_t[i] = TW'($urandom);
            wb_done[i] = 1'b0;
            if (m_d[i]) dirty_n++;
        end
        exp_idx = 0; sweep_reads = 0; wb_cnt = 0;
    endtask

    task automatic pulse_req(input int len);
        @(negedge clk); flush_req_a = 1'b1;
        cycles(len);
        flush_req_a = 1'b0;
    endtask

    task automatic wait_done(input int base);
        for (int i = 0; i < 2000 && done_cnt == base; i++) @(negedge clk);
    endtask

    task automatic run_flush(input int hold, input bit snoops, input bit again);
        int dirty_n, base, rises, wait_c, valid_left;
        fill_store(dirty_n);
        base  = done_cnt;
        rises = rise_cnt;
        @(negedge clk); flush_req_a = 1'b1;
        cycles(hold);
        flush_req_a = 1'b0;
        wait_c = 0;
        while (!bus_req && wait_c < 10) begin @(negedge clk); wait_c++; end
        chk(bus_req && wait_c <= 3 + hold - 8, "R1 start latency", wait_c, 3);
        fork
            begin
                if (again) begin
                    cycles(10);
                    flush_req_a = 1'b1;
                end
            end
            begin
                if (snoops) begin
                    while (done_cnt == base) begin
                        cycles(2 + $urandom % 4);
                        snoop_valid = 1'b1;
                        case ($urandom % 3)
                            0: snoop_kind = 2'd0;
                            1: snoop_kind = 2'd1;
                            default: snoop_kind = 2'd3;
                        endcase
                        snoop_line = (TW+IW)'($urandom);
                        @(negedge clk);
                        snoop_valid = 1'b0;
                    end
                end
            end
        join_none
        wait_done(base);
        chk(done_cnt == base + 1, "R9 done pulse", done_cnt - base, 1);
        cycles(30);
        flush_req_a = 1'b0;
        cycles(5);
        chk(done_cnt == base + 1, "R10 no second flush", done_cnt - base, 1);
        chk(rise_cnt == rises + 1, "R10 bus request once", rise_cnt - rises, 1);
        chk(sweep_reads == N, "R3 every index read", sweep_reads, N);
        chk(wb_cnt == dirty_n, "R5 write-back count", wb_cnt, dirty_n);
        valid_left = 0;
        for (int i = 0; i < N; i++) if (m_v[i]) valid_left++;
        chk(valid_left == 0, "R4 store empty", valid_left, 0);
    endtask

    initial begin
        int base, rises, dn;
        void'($urandom(32'h1f2e3d4c));
        for (int i = 0; i < N; i++) begin
            m_v[i] = 1'b0; m_d[i] = 1'b0; m_t[i] = '0; wb_done[i] = 1'b0;
        end
        cycles(4);
        chk(!bus_req && !done && !retry && !wb_req && !tag_en, "R11 reset state", bus_req, 0);
        @(negedge clk); rst = 1'b0;
        cycles(2);

        // R1: a pulse one cycle short of the window is ignored
        rises = rise_cnt;
        pulse_req(7);
        cycles(20);
        chk(rise_cnt == rises && !bus_req, "R1 short pulse ignored", rise_cnt - rises, 0);

        run_flush(8, 1'b0, 1'b0);
        run_flush(8, 1'b1, 1'b0);
        run_flush(12, 1'b1, 1'b1);
        for (int r = 0; r < 3; r++) run_flush(8 + $urandom % 4, 1'b1, 1'b0);

        // R8: burst write snoops while the grant is held back
        gnt_hold = 1'b1;
        fill_store(dn);
        m_v[5] = 1'b1; m_d[5] = 1'b0; m_t[5] = 8'h3C;
        m_v[6] = 1'b1; m_d[6] = 1'b1; m_t[6] = 8'h11;
        base = done_cnt;
        pulse_req(8);
        cycles(4);
        chk(bus_req && !tag_en, "R2 waits for grant", bus_req, 1);
        snoop_win = 4;
        snoop_valid = 1'b1; snoop_kind = 2'd2; snoop_line = {8'h3C, 4'd5};
        @(negedge clk); snoop_valid = 1'b0;
        #1;
        chk(!retry, "R8 no retry on burst write", retry, 0);
        cycles(3);
        chk(!m_v[5], "R8 matching line cleared", m_v[5], 0);
        snoop_win = 4;
        snoop_valid = 1'b1; snoop_kind = 2'd2; snoop_line = {8'h22, 4'd6};
        @(negedge clk); snoop_valid = 1'b0;
        cycles(4);
        chk(m_v[6] && m_d[6], "R8 non-matching line kept", m_v[6], 1);
        cycles(6);
        chk(exp_idx == 0 && bus_req, "R2 no sweep before grant", exp_idx, 0);
        gnt_hold = 1'b0;
        wait_done(base);
        chk(done_cnt == base + 1, "R9 flush completes after grant", done_cnt - base, 1);
        cycles(4);

        // R11: reset in the middle of a sweep
        fill_store(dn);
        base = done_cnt;
        pulse_req(8);
        for (int i = 0; i < 200 && exp_idx < 6; i++) @(negedge clk);
        rst = 1'b1;
        @(negedge clk); #1;
        chk(!bus_req && !wb_req && !done && !tag_en, "R11 reset aborts", bus_req, 0);
        @(negedge clk); rst = 1'b0;
        rises = rise_cnt;
        cycles(30);
        chk(rise_cnt == rises && done_cnt == base, "R11 stays idle", rise_cnt - rises, 0);

        summary();
    end
endmodule